// File: doc/BRIEF.md
# Three-Wire Serial ADC Read Controller

This block is the host side of a serial link to a multi-channel analog-to-digital converter that uses three wires: an active-low chip select, a serial clock and one data wire shared by both directions. A pulse on `start` opens one transaction. The controller pulls chip select low and sends a four-bit command on the shared wire. It then lets go of the wire so the converter can drive it, and clocks in a ten-bit result. At the end it raises chip select, loads the result register and pulses `done` for one cycle.

The serial clock comes from the system clock through a programmable divider. Each half period of the serial clock lasts `div_half + 1` system clocks. The shared wire is brought out as three signals: a driven value, an output enable and a sensed value. The tristate pad sits outside the block.

The state machine has four named states:
- `ST_IDLE` waits for `start` (transition *launch*).
- `ST_CMD` toggles the clock through the four command bits. After the fourth rising edge it goes to the next state (transition *turnaround*).
- `ST_RES` toggles the clock through ten result samples. After the tenth sampling edge it goes to the next state (transition *last_sample*).
- `ST_LAST` waits one more half period, then returns to idle (transition *finish*).

Top module: `adc3w_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sd_oe` is 0, `done` is 0 and `busy` is 0. While idle, `cs_n` stays high and `sclk` stays low.
- R2: One cycle after `start` is seen in idle, `cs_n` is 0, `busy` is 1, `sd_oe` is 1 and `sd_o` shows the first command bit.
- R3: The command is sent in this order: a constant 1, then `sgl_diff`, then `odd_sign`, then `msb_first`. Each bit is placed while `sclk` is low and is held through the following rising edge.
- R4: Each half period of `sclk` lasts `div_half+1` system clocks. `done` rises exactly 28·(`div_half`+1) cycles after the clock edge that accepts `start`.
- R5: `sd_oe` falls at the 4th rising edge of `sclk`, so it is low before the 4th falling edge. It stays low until the next transaction begins.
- R6: Ten result bits are sampled from `sd_i` on rising edges 5 through 14. When `msb_first` is 1, the first sampled bit is result bit 9.
- R7: When `msb_first` is 0, the first sampled bit is result bit 0 and the last is result bit 9.
- R8: One half period after the 14th rising edge, `sclk` falls, `cs_n` rises and `done` is high for exactly one cycle. The new result is on `result` in that same cycle.
- R9: `start` has no effect while `busy` is 1. No second transaction follows the one in progress.
- R10: `sgl_diff`, `odd_sign` and `msb_first` are captured when `start` is accepted. Changing them during a transaction does not change the command or the bit order.
- R11: `result` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion read |
| div_half | input | DIV_W | Half period of the serial clock, in system clocks, minus one |
| sgl_diff | input | 1 | Single-ended/differential select for the command |
| odd_sign | input | 1 | Odd/sign select for the command |
| msb_first | input | 1 | Bit-order flag: 1 = result arrives MSB first |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| sd_o | output | 1 | Value driven onto the shared data wire |
| sd_oe | output | 1 | Output enable for the shared data wire |
| sd_i | input | 1 | Value sensed on the shared data wire |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| result | output | RES_W | Last completed conversion result |

## Verification
The bench sweeps every command combination against divider settings 0 to 3. A converter model decodes the command it actually received and drives data back in the order that command asked for. A design that released the wire late would collide with the converter model after the 4th falling edge. A design that released it early, or sent the command bits in the wrong order, would return the wrong captured command. A design that ignored the bit-order flag would return a bit-reversed result. A miscounted divider or bit counter would shift the cycle in which `done` rises. Half of the transactions change the command inputs and pulse `start` partway through. A design that did not capture the inputs, or that re-armed while busy, would send a mixed command or lower chip select a second time.

// File: rtl/adc3w_pkg.sv
package adc3w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_RES,
        ST_LAST
    } adc3w_state_e;

    localparam int CMD_BITS = 4;
endpackage

// File: rtl/adc3w_tick.sv
module adc3w_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc3w_cmdfmt.sv
module adc3w_cmdfmt
    import adc3w_pkg::*;
(
    input  logic       sgl,
    input  logic       odd,
    input  logic       msbf,
    input  logic [1:0] idx,
    output logic       bit_o
);
    logic [CMD_BITS-1:0] word;

    // Sent from the top bit down: marker, mode, polarity, order.
    assign word  = {1'b1, sgl, odd, msbf};
    assign bit_o = word[CMD_BITS-1-int'(idx)];
endmodule

// File: rtl/adc3w_rxshift.sv
module adc3w_rxshift #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             msbf,
    input  logic             din,
    output logic [RES_W-1:0] data
);
    logic [RES_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear) begin
            sh_q <= '0;
        end else if (shift_en) begin
            if (msbf) begin
                sh_q <= {sh_q[RES_W-2:0], din};
            end else begin
                sh_q <= {din, sh_q[RES_W-1:1]};
            end
        end
    end

    assign data = sh_q;
endmodule

// File: rtl/adc3w_reader.sv
module adc3w_reader
    import adc3w_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_half,
    input  logic             sgl_diff,
    input  logic             odd_sign,
    input  logic             msb_first,
    output logic             sclk,
    output logic             cs_n,
    output logic             sd_o,
    output logic             sd_oe,
    input  logic             sd_i,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    localparam int CNT_W   = (RES_W > CMD_BITS) ? $clog2(RES_W) : $clog2(CMD_BITS);
    localparam int CMD_TOP = CMD_BITS - 1;
    localparam int RES_TOP = RES_W - 1;

    adc3w_state_e state_q, state_d;

    logic             sclk_q, cs_n_q, oe_q, sdo_q, done_q;
    logic [CNT_W-1:0] bit_q;
    logic             sgl_q, odd_q, msbf_q;
    logic [RES_W-1:0] result_q;
    logic             tick, accept, sample, next_cmd_bit;
    logic [RES_W-1:0] rx_data;
    logic [1:0]       fmt_idx;

    assign accept  = (state_q == ST_IDLE) && start;
    assign sample  = (state_q == ST_RES) && tick && !sclk_q;
    assign fmt_idx = 2'(bit_q + 1'b1);

    adc3w_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (state_q != ST_IDLE),
        .div   (div_half),
        .tick  (tick)
    );

    adc3w_cmdfmt u_fmt (
        .sgl   (sgl_q),
        .odd   (odd_q),
        .msbf  (msbf_q),
        .idx   (fmt_idx),
        .bit_o (next_cmd_bit)
    );

    adc3w_rxshift #(.RES_W(RES_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (sample),
        .msbf     (msbf_q),
        .din      (sd_i),
        .data     (rx_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CMD;
            ST_CMD:  if (tick && !sclk_q && bit_q == CNT_W'(CMD_TOP)) state_d = ST_RES;
            ST_RES:  if (tick && !sclk_q && bit_q == CNT_W'(RES_TOP)) state_d = ST_LAST;
            ST_LAST: if (tick) state_d = ST_IDLE;
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            oe_q     <= 1'b0;
            sdo_q    <= 1'b0;
            done_q   <= 1'b0;
            bit_q    <= '0;
            sgl_q    <= 1'b0;
            odd_q    <= 1'b0;
            msbf_q   <= 1'b1;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cs_n_q <= 1'b0;
                        oe_q   <= 1'b1;
                        sdo_q  <= 1'b1;
                        bit_q  <= '0;
                        sgl_q  <= sgl_diff;
                        odd_q  <= odd_sign;
                        msbf_q <= msb_first;
                    end
                end
                ST_CMD: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            if (bit_q == CNT_W'(CMD_TOP)) begin
                                oe_q  <= 1'b0;
                                bit_q <= '0;
                            end
                        end else begin
                            sclk_q <= 1'b0;
                            sdo_q  <= next_cmd_bit;
                            bit_q  <= bit_q + 1'b1;
                        end
                    end
                end
                ST_RES: begin
                    if (tick) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                        end else begin
                            sclk_q <= 1'b1;
                            if (bit_q != CNT_W'(RES_TOP)) bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_LAST: begin
                    if (tick) begin
                        sclk_q   <= 1'b0;
                        cs_n_q   <= 1'b1;
                        done_q   <= 1'b1;
                        result_q <= rx_data;
                    end
                end
            endcase
        end
    end

    assign sclk   = sclk_q;
    assign cs_n   = cs_n_q;
    assign sd_o   = sdo_q;
    assign sd_oe  = oe_q;
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;
endmodule

// File: rtl/adc3w_reader_chk.sv
module adc3w_reader_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sclk,
    input logic             cs_n,
    input logic             sd_oe,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] result
);
    assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk && !sd_oe));

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (!cs_n && sd_oe && busy));

    assert_release_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> sclk);

    assert_no_drive_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sd_oe);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !sclk && !busy));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
endmodule

bind adc3w_reader adc3w_reader_chk #(.RES_W(RES_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .sclk   (sclk),
    .cs_n   (cs_n),
    .sd_oe  (sd_oe),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/adc3w_reader_test.sv
module adc3w_reader_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int RES_W      = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [DIV_W-1:0] div_half = '0;
    logic             sgl_diff = 1'b0, odd_sign = 1'b0, msb_first = 1'b1;
    logic             sclk, cs_n, sd_o, sd_oe, sd_i, busy, done;
    logic [RES_W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    // converter model state
    int               rise_n = 0, fall_n = 0;
    logic [3:0]       cap = '0;
    logic [RES_W-1:0] tx = '0;
    logic             drv = 1'b0, drv_bit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sd_i = drv ? drv_bit : (sd_oe ? sd_o : 1'b1);

    adc3w_reader #(.DIV_W(DIV_W), .RES_W(RES_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .div_half(div_half),
        .sgl_diff(sgl_diff), .odd_sign(odd_sign), .msb_first(msb_first),
        .sclk(sclk), .cs_n(cs_n), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    always @(negedge cs_n) begin
        rise_n = 0;
        fall_n = 0;
        drv    = 1'b0;
    end

    always @(posedge cs_n) drv = 1'b0;

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rise_n < 4) cap[3-rise_n] = sd_o;   // R3 capture
            rise_n++;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            fall_n++;
            if (fall_n < 4) chk("R5 oe held during command", int'(sd_oe), 1);
            if (fall_n == 4) begin
                chk("R5 released before 4th fall", int'(sd_oe), 0);
                drv = 1'b1;
            end
            if (fall_n >= 4 && fall_n < 4 + RES_W) begin
                drv_bit = cap[0] ? tx[RES_W-1-(fall_n-4)] : tx[fall_n-4];
            end
        end
    end

    // bus contention watch
    always @(negedge clk) begin
        if (drv && sd_oe) chk("R5 contention", 1, 0);
    end

    // global watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_txn(input int d, input logic s, input logic o, input logic m,
                           input logic [RES_W-1:0] val, input bit disturb);
        int n = 0;
        int exp_n;
        logic [RES_W-1:0] held;
        exp_n = 28 * (d + 1) + 1;
        tx = val;
        @(negedge clk);
        div_half  = DIV_W'(d);
        sgl_diff  = s;
        odd_sign  = o;
        msb_first = m;
        start     = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 cs low", int'(cs_n), 0);
        chk("R2 busy", int'(busy), 1);
        chk("R2 drive start bit", int'({sd_oe, sd_o}), 3);
        while (!done && n < exp_n + 40) begin
            if (disturb && n == 6) begin
                sgl_diff  = ~s;
                odd_sign  = ~o;
                msb_first = ~m;
                start     = 1'b1;        // R9: ignored while busy
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R4 cycles to done", n, exp_n);
        chk(disturb ? "R10 command captured" : "R3 command order", int'(cap), int'({1'b1, s, o, m}));
        chk(m ? "R6 msb-first result" : "R7 lsb-first result", int'(result), int'(val));
        chk("R8 end state", int'({cs_n, sclk, busy, sd_oe}), 4'b1000);
        held = result;
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
        for (int k = 0; k < 3 * (d + 1) + 4; k++) begin
            @(negedge clk);
            if (!cs_n || done) chk("R9 no second transaction", int'({cs_n, done}), 2);
        end
        chk("R11 result held", int'(result), int'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({cs_n, sclk, sd_oe, done, busy}), 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle outputs", int'({cs_n, sclk, sd_oe, done, busy}), 5'b10000);
        for (int d = 0; d < 4; d++) begin
            for (int c = 0; c < 8; c++) begin
                logic [RES_W-1:0] v;
                v = RES_W'((c * 173 + d * 59 + 'h2A5) & 'h3FF);
                run_txn(d, c[2], c[1], c[0], v, c[0] ^ d[0]);
            end
        end
        run_txn(1, 1'b0, 1'b0, 1'b0, 10'h001, 1'b0);   // R7 single low bit
        run_txn(1, 1'b1, 1'b1, 1'b1, 10'h200, 1'b0);   // R6 single high bit
        run_txn(2, 1'b0, 1'b1, 1'b1, 10'h3FF, 1'b1);
        run_txn(0, 1'b1, 1'b0, 1'b0, 10'h000, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule